// File: doc/BRIEF.md
# Byte-Wide Flash Bank Erase and Program Sequencer

This block rewrites one bank of byte-wide flash. It erases the bank, reads every location back to confirm the erase, programs every location from a source byte buffer, and reads the bank back again to compare it with that buffer. It speaks one of two command dialects, chosen by `unlock_mode` when a run starts. The status dialect writes a command byte and then reads a status byte whose top bit signals completion. The unlock dialect opens each operation with fixed unlock writes to two magic addresses and treats the operation as finished when two back-to-back reads return the same value.

The flash bus is a plain synchronous byte port with one-cycle write and read strobes. Read data must be valid in the cycle after a read strobe. The source buffer is read through a synchronous port whose data is valid one cycle after the address. After every command write the block waits `SETTLE` idle cycles. Every completion poll gives up after `TIMEOUT` iterations. The bank always starts at flash address 0. Choosing which physical bank that is happens outside this block.

Top module: `flash_bank_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `fl_we` and `fl_re` are low and `err` is zero.
- R2: Status dialect erase writes 0x20 and then 0xD0 to address 0. Each poll then writes 0x70 to address 0 and reads address 0, repeating until read bit 7 is 1. The erase ends by writing 0x50 and then 0xFF to address 0.
- R3: Status dialect programming does the following for each byte index i from 0 upward: write 0x40 to address i, write the source byte to address i, and poll as in R2. After the byte loop, 0x50 and then 0xFF are written to address 0.
- R4: Unlock dialect erase writes AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh and then 30@0. Each program byte is AA@555h, 55@2AAh, A0@555h, then the data byte at its own address. Polls are pairs of reads of address 0 with no writes, and a poll completes when the two reads are equal. After the erase and again after the program loop, F0h is written to address 0.
- R5: After every write strobe, neither strobe is asserted for the next `SETTLE` cycles.
- R6: A poll that has not completed after `TIMEOUT` iterations sets `err[0]` during erase or `err[2]` during programming. A program timeout ends the byte loop at once, and cleanup and verify still run.
- R7: The erase verify reads every bank address and sets `err[1]` if any value is not 0xFF. The program verify sets `err[3]` if any location differs from the source byte.
- R8: If `err[0]` or `err[1]` is set after the erase verify, no programming write is issued and the run ends.
- R9: In the status dialect, a completing status read with any of bits 5..3 set sets `err[4]`.
- R10: `busy` rises the cycle after an accepted `start`. `done` is a one-cycle pulse in the last busy cycle. `start` is ignored while `busy` is high, including the `done` cycle. `err` holds its value until the next accepted `start` clears it.
- R11: `fl_we` and `fl_re` are never high together. `fl_rdata` is taken the cycle after `fl_re`, and `src_data` the cycle after `src_addr` settles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| unlock_mode | input | 1 | 0: status dialect, 1: unlock dialect; latched at start |
| fl_addr | output | FAW | Flash byte address within the bank |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |
| src_addr | output | AW | Source buffer address |
| src_data | input | 8 | Source buffer data, valid the cycle after `src_addr` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 5 | [0] erase timeout, [1] erase verify, [2] program timeout, [3] program verify, [4] status error bits |

## Verification
The end of one run and the request for the next can fall in the same cycle. The bench raises `start` in exactly the cycle where `done` is high. It then judges that the request was dropped: `busy` must be low on the following cycle and stay low, and only one `done` pulse may have occurred. A request that arrives in the middle of a run is also injected, and the complete write log must then match a single undisturbed run. A poll timeout and the skip of the programming phase can follow one another at the end of the erase. The timeout cases check that cleanup and verify still run before the block either stops or skips ahead.

// File: rtl/flash_bank_sequencer.sv
module flash_bank_sequencer #(
  parameter int BANK_BYTES = 8192,
  parameter int FAW = 13,
  parameter int SETTLE = 100,
  parameter int TIMEOUT = 1000000,
  localparam int AW = $clog2(BANK_BYTES)
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           unlock_mode,
  output logic [FAW-1:0] fl_addr,
  output logic [7:0]     fl_wdata,
  output logic           fl_we,
  output logic           fl_re,
  input  logic [7:0]     fl_rdata,
  output logic [AW-1:0]  src_addr,
  input  logic [7:0]     src_data,
  output logic           busy,
  output logic           done,
  output logic [4:0]     err
);
  localparam int GW = $clog2(SETTLE + 2);
  localparam int PW = $clog2(TIMEOUT + 1);
  localparam logic [AW-1:0] LAST = AW'(BANK_BYTES - 1);
  localparam logic [FAW-1:0] MAGIC_A = FAW'(12'h555);
  localparam logic [FAW-1:0] MAGIC_B = FAW'(12'h2AA);

  typedef enum logic [3:0] {S_IDLE, S_SEQ, S_PCMD, S_PRD, S_PCAP, S_CLR, S_VRD, S_VCAP, S_FIN} st_t;

  st_t            st;
  logic           mode, prog, second;
  logic [2:0]     step;
  logic [AW-1:0]  idx;
  logic [GW-1:0]  gap;
  logic [PW-1:0]  polls;
  logic [7:0]     first;
  logic [4:0]     err_q;
  logic [FAW-1:0] cmd_a;
  logic [7:0]     cmd_d;
  logic           cmd_last;

  wire            act    = (gap == '0);
  wire [FAW-1:0]  idx_a  = FAW'(idx);
  wire            ready  = mode ? (second && ((first ^ fl_rdata) == 8'h00)) : fl_rdata[7];
  wire            expire = (polls == PW'(TIMEOUT - 1));
  wire            mis    = (fl_rdata != (prog ? src_data : 8'hFF));

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign err      = err_q;
  assign src_addr = idx;
  assign fl_we    = act && (st == S_SEQ || st == S_CLR || st == S_PCMD);
  assign fl_re    = act && (st == S_PRD || st == S_VRD);
  assign fl_addr  = cmd_a;
  assign fl_wdata = cmd_d;

  always_comb begin
    cmd_a = '0;
    cmd_d = 8'h00;
    cmd_last = 1'b1;
    case (st)
      S_SEQ: begin
        if (!mode) begin
          cmd_last = (step == 3'd1);
          if (!prog) cmd_d = (step == 3'd0) ? 8'h20 : 8'hD0;
          else begin
            cmd_a = idx_a;
            cmd_d = (step == 3'd0) ? 8'h40 : src_data;
          end
        end else if (!prog) begin
          cmd_last = (step == 3'd5);
          case (step)
            3'd0, 3'd3: begin cmd_a = MAGIC_A; cmd_d = 8'hAA; end
            3'd1, 3'd4: begin cmd_a = MAGIC_B; cmd_d = 8'h55; end
            3'd2:       begin cmd_a = MAGIC_A; cmd_d = 8'h80; end
            default:    cmd_d = 8'h30;
          endcase
        end else begin
          cmd_last = (step == 3'd3);
          case (step)
            3'd0:    begin cmd_a = MAGIC_A; cmd_d = 8'hAA; end
            3'd1:    begin cmd_a = MAGIC_B; cmd_d = 8'h55; end
            3'd2:    begin cmd_a = MAGIC_A; cmd_d = 8'hA0; end
            default: begin cmd_a = idx_a;   cmd_d = src_data; end
          endcase
        end
      end
      S_CLR: begin
        if (!mode) begin
          cmd_last = (step == 3'd1);
          cmd_d = (step == 3'd0) ? 8'h50 : 8'hFF;
        end else cmd_d = 8'hF0;
      end
      S_PCMD: cmd_d = 8'h70;
      S_VRD:  cmd_a = idx_a;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode <= 1'b0; prog <= 1'b0; second <= 1'b0;
      step <= '0; idx <= '0; gap <= '0; polls <= '0; first <= '0; err_q <= '0;
    end else begin
      if (!act) gap <= gap - 1'b1;
      if (fl_we) gap <= GW'(SETTLE);
      case (st)
        S_IDLE: if (start) begin
          mode <= unlock_mode; prog <= 1'b0; step <= '0; idx <= '0;
          err_q <= '0; second <= 1'b0; st <= S_SEQ;
        end
        S_SEQ: if (act) begin
          if (cmd_last) begin
            step <= '0; polls <= '0; second <= 1'b0;
            st <= mode ? S_PRD : S_PCMD;
          end else step <= step + 1'b1;
        end
        S_PCMD: if (act) st <= S_PRD;
        S_PRD:  if (act) st <= S_PCAP;
        S_PCAP: begin
          if (mode && !second) begin
            first <= fl_rdata; second <= 1'b1; st <= S_PRD;
          end else begin
            second <= 1'b0;
            polls <= polls + 1'b1;
            if (ready || expire) begin
              if (ready && !mode && ((fl_rdata & 8'h38) != 8'h00)) err_q[4] <= 1'b1;
              if (!ready) err_q[prog ? 2 : 0] <= 1'b1;
              step <= '0;
              if (!prog || !ready || idx == LAST) st <= S_CLR;
              else begin idx <= idx + 1'b1; st <= S_SEQ; end
            end else st <= mode ? S_PRD : S_PCMD;
          end
        end
        S_CLR: if (act) begin
          if (cmd_last) begin step <= '0; idx <= '0; st <= S_VRD; end
          else step <= step + 1'b1;
        end
        S_VRD: if (act) st <= S_VCAP;
        S_VCAP: begin
          if (mis) err_q[prog ? 3 : 1] <= 1'b1;
          if (idx == LAST) begin
            if (!prog && !(err_q[0] || err_q[1] || mis)) begin
              prog <= 1'b1; idx <= '0; step <= '0; st <= S_SEQ;
            end else st <= S_FIN;
          end else begin
            idx <= idx + 1'b1; st <= S_VRD;
          end
        end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(fl_we && fl_re));
  // R5
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SETTLE > 0 && fl_we) |=> !(fl_we || fl_re));
  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(fl_we || fl_re));
  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) polls <= PW'(TIMEOUT));
  // R8
  erase_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && prog) |-> !(err_q[0] || err_q[1]));
endmodule

// File: tb/flash_bank_sequencer_tb.sv
module flash_bank_sequencer_tb;
  localparam int NB = 16;
  localparam int FAW = 12;
  localparam int ST = 2;
  localparam int TMO = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, unlock_mode = 1'b0;
  logic [FAW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata = 8'h00, src_data = 8'h00;
  logic fl_we, fl_re, busy, done;
  logic [3:0] src_addr;
  logic [4:0] err;

  always #5 clk = ~clk;

  flash_bank_sequencer #(.BANK_BYTES(NB), .FAW(FAW), .SETTLE(ST), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .unlock_mode(unlock_mode),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
    .src_addr(src_addr), .src_data(src_data), .busy(busy), .done(done), .err(err));

  int checks = 0, fails = 0;
  logic [7:0] mem [NB];
  logic [7:0] src [NB];
  logic [7:0] emem [NB];
  logic [11:0] la [256];
  logic [7:0]  ld [256];
  logic [11:0] ea [256];
  logic [7:0]  ed [256];
  int nlog = 0, ne = 0, cyc = 0, last_we = -1, min_gap = 1000, ndone = 0, both = 0;
  int bsy = 0, lat_e = 0, lat_p = 0, stuck = 0;
  logic [7:0] serr = 8'h00;
  logic rd_status = 1'b0, armed = 1'b0, esetup = 1'b0, tog = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (done) ndone++;
    if (fl_we && fl_re) both++;
    if ((fl_we || fl_re) && last_we >= 0 && (cyc - last_we) < min_gap) min_gap = cyc - last_we;
    src_data <= src[src_addr];
    if (fl_we) begin
      last_we = cyc;
      if (nlog < 256) begin la[nlog] = fl_addr; ld[nlog] = fl_wdata; end
      nlog++;
      if (armed) begin
        if (fl_addr < NB)
          mem[fl_addr[3:0]] = mem[fl_addr[3:0]] &
            ((stuck == 2 && fl_addr == 5) ? (fl_wdata & 8'hFE) : fl_wdata);
        bsy = lat_p; armed = 1'b0; rd_status = 1'b1; tog = 1'b0;
      end else if (!unlock_mode) begin
        case (fl_wdata)
          8'h20: esetup = 1'b1;
          8'hD0: if (esetup) begin
            for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
            if (stuck == 1) mem[3] = 8'h7F;
            bsy = lat_e; rd_status = 1'b1; esetup = 1'b0;
          end
          8'h70: rd_status = 1'b1;
          8'h40: armed = 1'b1;
          8'hFF: begin rd_status = 1'b0; bsy = 0; end
          default: ;
        endcase
      end else begin
        if (fl_addr == 12'h555 && fl_wdata == 8'hA0) armed = 1'b1;
        else if (fl_addr == 0 && fl_wdata == 8'h30) begin
          for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
          if (stuck == 1) mem[3] = 8'h7F;
          bsy = lat_e; tog = 1'b0;
        end else if (fl_wdata == 8'hF0) bsy = 0;
      end
    end
    if (fl_re) begin
      if (!unlock_mode && rd_status) begin
        fl_rdata <= (bsy == 0) ? (8'h80 | serr) : 8'h00;
        if (bsy > 0) bsy--;
      end else if (unlock_mode && bsy > 0) begin
        fl_rdata <= tog ? 8'h40 : 8'h00;
        tog = ~tog; bsy--;
      end else fl_rdata <= (fl_addr < NB) ? mem[fl_addr[3:0]] : 8'h00;
    end
  end

  task automatic push(input logic [11:0] a, input logic [7:0] d);
    ea[ne] = a; ed[ne] = d; ne++;
  endtask

  task automatic build(input bit m, output logic [4:0] xe);
    bit etimo, ptimo, efail;
    int np;
    ne = 0; xe = '0;
    if (!m) begin
      push(0, 8'h20); push(0, 8'hD0);
      etimo = (lat_e + 1 > TMO);
      np = etimo ? TMO : lat_e + 1;
      for (int k = 0; k < np; k++) push(0, 8'h70);
      push(0, 8'h50); push(0, 8'hFF);
    end else begin
      push(12'h555, 8'hAA); push(12'h2AA, 8'h55); push(12'h555, 8'h80);
      push(12'h555, 8'hAA); push(12'h2AA, 8'h55); push(0, 8'h30);
      etimo = (lat_e / 2 + 1 > TMO);
      push(0, 8'hF0);
    end
    for (int i = 0; i < NB; i++) emem[i] = 8'hFF;
    if (stuck == 1) emem[3] = 8'h7F;
    efail = etimo || (stuck == 1);
    xe[0] = etimo; xe[1] = (stuck == 1);
    xe[4] = !m && ((serr & 8'h38) != 0) && !etimo;
    if (!efail) begin
      ptimo = 1'b0;
      for (int i = 0; i < NB && !ptimo; i++) begin
        if (!m) begin
          push(12'(i), 8'h40); push(12'(i), src[i]);
          ptimo = (lat_p + 1 > TMO);
          np = ptimo ? TMO : lat_p + 1;
          for (int k = 0; k < np; k++) push(0, 8'h70);
        end else begin
          push(12'h555, 8'hAA); push(12'h2AA, 8'h55); push(12'h555, 8'hA0); push(12'(i), src[i]);
          ptimo = (lat_p / 2 + 1 > TMO);
        end
        emem[i] = (stuck == 2 && i == 5) ? (src[i] & 8'hFE) : src[i];
      end
      if (!m) begin push(0, 8'h50); push(0, 8'hFF); end
      else push(0, 8'hF0);
      xe[2] = ptimo;
      for (int i = 0; i < NB; i++) if (emem[i] != src[i]) xe[3] = 1'b1;
    end
  endtask

  task automatic run(input string tag, input bit m, input int le, input int lp,
                     input logic [7:0] se, input int sk, input int pat, input bit intr, input bit at_done);
    logic [4:0] xe;
    int w, bad;
    lat_e = le; lat_p = lp; serr = se; stuck = sk;
    for (int i = 0; i < NB; i++) begin
      src[i] = (pat == 0) ? 8'(i * 16 + 3) : (8'(i) ^ 8'hA5);
      mem[i] = 8'h00;
    end
    build(m, xe);
    nlog = 0; ndone = 0; armed = 1'b0; esetup = 1'b0; rd_status = 1'b0; bsy = 0;
    @(negedge clk); unlock_mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", busy, 1);
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk); w++;
      if (intr && w == 30) start = 1'b1;
      if (intr && w == 31) start = 1'b0;
    end
    chk(w < 20000, {tag, " watchdog"}, w, 0);
    if (at_done) start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (at_done) begin
      chk(busy == 1'b0, "R10 start in done cycle ignored", busy, 0);
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R10 still idle after done-cycle start", busy, 0);
    end else repeat (3) @(negedge clk);
    chk(ndone == 1, "R10 single done pulse", ndone, 1);
    chk(err == xe, {tag, " err code"}, err, xe);
    chk(err == xe, "R10 err held after done", err, xe);
    bad = -1;
    if (nlog != ne) bad = (nlog < ne) ? nlog : ne;
    for (int i = 0; i < ne && i < nlog && bad < 0; i++)
      if (la[i] != ea[i] || ld[i] != ed[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " write sequence"},
             (bad < nlog) ? {la[bad], ld[bad]} : -1, (bad < ne) ? {ea[bad], ed[bad]} : -1);
    bad = -1;
    for (int i = 0; i < NB; i++) if (mem[i] != emem[i] && bad < 0) bad = i;
    chk(bad < 0, "R7 bank contents", (bad < 0) ? 0 : mem[bad], (bad < 0) ? 0 : emem[bad]);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin src[i] = 8'h00; mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !fl_we && !fl_re && err == 0, "R1 reset state",
        {busy, done, fl_we, fl_re, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && err == 0, "R1 idle after reset", busy, 0);
    run("R2 R3 status clean",          1'b0, 2, 2, 8'h00, 0, 0, 1'b0, 1'b1);
    run("R4 R11 unlock clean",         1'b1, 4, 2, 8'h00, 0, 1, 1'b0, 1'b0);
    run("R9 status error bits",        1'b0, 1, 0, 8'h10, 0, 1, 1'b0, 1'b0);
    run("R6 R8 status erase timeout",  1'b0, 20, 2, 8'h00, 0, 0, 1'b0, 1'b0);
    run("R6 unlock program timeout",   1'b1, 2, 40, 8'h00, 0, 1, 1'b0, 1'b0);
    run("R7 R8 erase verify fail",     1'b0, 0, 0, 8'h00, 1, 0, 1'b0, 1'b0);
    run("R7 unlock program verify",    1'b1, 0, 2, 8'h00, 2, 0, 1'b0, 1'b0);
    run("R10 start mid-run ignored",   1'b0, 3, 1, 8'h00, 0, 1, 1'b1, 1'b0);
    run("R3 status zero latency",      1'b0, 0, 0, 8'h00, 0, 0, 1'b0, 1'b0);
    // R5
    chk(min_gap >= ST + 1, "R5 settle gap", min_gap, ST + 1);
    // R11
    chk(both == 0, "R11 strobe exclusivity", both, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule